// File: doc/BRIEF.md
# Late-Write Memory Front End with Read Bypass

This block puts a deferred-write stage in front of a small synchronous memory array. A write command carries only its address. The double-width data word for that write arrives on the following clock. The address and the word wait in a one-entry holding buffer and are written into the array only when the next write command arrives. Any number of reads may come in between.

Every read compares its address with the held write address. On a match, the read takes the held word instead of the array contents. If the word is arriving in the same cycle as the read, the read takes the incoming word. Hits and misses use the same registered output path, so a read returns its data exactly one clock after the command in both cases.

A user issues one command per cycle on a single command port. The data for a write is driven one cycle later on the write-data port, which may coincide with the next command.

Top module: `late_write_sram`

## Requirements
- R1: After reset, `rd_valid` is 0, `rd_data` is 0, and no write is pending.
- R2: A read command (`cmd_vld`=1, `cmd_wr`=0) produces `rd_valid`=1 and its `rd_data` on the first rising edge after the command. Hits and misses have the same latency. `rd_valid` is 0 after any cycle without a read.
- R3: For a write command (`cmd_vld`=1, `cmd_wr`=1), the data word is taken from `wdata` in the cycle after the command. `wdata` in the command cycle itself is not the stored word.
- R4: A write is held back from the array until the next write command. At that command it is committed, so reads of its address keep returning its data after the buffer moves on to a new address.
- R5: A read whose address equals the pending write address returns the buffered word.
- R6: A read whose address differs from the pending write address returns the array contents.
- R7: A read issued in the cycle where the pending write's data is arriving, to that write's address, returns the arriving `wdata`.
- R8: Back-to-back write commands work correctly. The first write's data arrives in the same cycle as the second command and is the word committed for the first address.
- R9: `rd_data` keeps its value in every cycle without a read. Repeated reads of one address return the same value.
- R10: `wdata` has no effect in cycles that are not the data cycle of a write.
- R11: A second write to an address supersedes the first, for both bypassed and committed reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | A command is present this cycle |
| cmd_wr | input | 1 | 1 = write command, 0 = read command |
| cmd_addr | input | ADDR_W | Command address |
| wdata | input | 2*DATA_W | Write word, sampled in the cycle after a write command |
| rd_valid | output | 1 | `rd_data` was loaded by a read on the last edge |
| rd_data | output | 2*DATA_W | Registered read word |

## Verification
A wrong held address, a stale valid flag or a lost data capture shows up only when a read targets the affected address. The bench therefore reads each written address in three situations: while the data is still arriving, while the data is held in the buffer, and after a later write has pushed it into the array. A wrong commit source, such as a back-to-back write committing the stale held word, appears at `rd_data` one clock after the first read of that address that follows the commit. A corrupt hold path appears as a change of `rd_data` in the very next idle cycle.

// File: rtl/late_write_sram.sv
module late_write_sram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_vld,
  input  logic                  cmd_wr,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic [2*DATA_W-1:0]   wdata,
  output logic                  rd_valid,
  output logic [2*DATA_W-1:0]   rd_data
);
  localparam int WORD_W = 2 * DATA_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              buf_vld;
  logic              data_due;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [WORD_W-1:0] wr_data_q;

  logic              is_wr, is_rd, hit;
  logic [WORD_W-1:0] buf_word, rd_word;

  assign is_wr    = cmd_vld & cmd_wr;
  assign is_rd    = cmd_vld & ~cmd_wr;
  assign buf_word = data_due ? wdata : wr_data_q;
  assign hit      = buf_vld && (cmd_addr == wr_addr_q);
  assign rd_word  = hit ? buf_word : mem[cmd_addr];

  always_ff @(posedge clk) begin
    if (is_wr && buf_vld) mem[wr_addr_q] <= buf_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_vld   <= 1'b0;
      data_due  <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      data_due <= is_wr;
      rd_valid <= is_rd;
      if (is_wr) begin
        buf_vld   <= 1'b1;
        wr_addr_q <= cmd_addr;
      end
      if (data_due) wr_data_q <= wdata;
      if (is_rd) rd_data <= rd_word;
    end
  end
endmodule

// File: rtl/late_write_sram_chk.sv
module late_write_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_vld,
  input logic                cmd_wr,
  input logic [ADDR_W-1:0]   cmd_addr,
  input logic [2*DATA_W-1:0] wdata,
  input logic                rd_valid,
  input logic [2*DATA_W-1:0] rd_data,
  input logic                buf_vld,
  input logic                data_due,
  input logic [ADDR_W-1:0]   wr_addr_q,
  input logic [2*DATA_W-1:0] wr_data_q
);
  // R2
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cmd_wr) |=> rd_valid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_vld && !cmd_wr) |=> !rd_valid);
  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_vld && !cmd_wr) |=> $stable(rd_data));
  // R4
  write_marks_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_wr) |=> (buf_vld && data_due));
  // R3
  data_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_due |=> (wr_data_q == $past(wdata)));
  // R5
  bypass_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cmd_wr && buf_vld && !data_due && cmd_addr == wr_addr_q)
      |=> (rd_data == $past(wr_data_q)));
  // R7
  bypass_arriving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cmd_wr && buf_vld && data_due && cmd_addr == wr_addr_q)
      |=> (rd_data == $past(wdata)));
endmodule

bind late_write_sram late_write_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/late_write_sram_tb_top.sv
module late_write_sram_tb_top;
  localparam int AW = 6;
  localparam int DW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_vld = 1'b0;
  logic            cmd_wr = 1'b0;
  logic [AW-1:0]   cmd_addr = '0;
  logic [2*DW-1:0] wdata = '0;
  logic            rd_valid;
  logic [2*DW-1:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  late_write_sram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_wr(cmd_wr),
    .cmd_addr(cmd_addr), .wdata(wdata), .rd_valid(rd_valid), .rd_data(rd_data));

  task automatic check(input string req, input logic [2*DW-1:0] act, input logic [2*DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic w, input logic [AW-1:0] a, input logic [2*DW-1:0] d);
    @(negedge clk);
    cmd_vld = v; cmd_wr = w; cmd_addr = a; wdata = d;
    @(posedge clk);
    #1;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a,
                        input logic [2*DW-1:0] d, input logic [2*DW-1:0] exp);
    cyc(1'b1, 1'b0, a, d);
    check({req, " rd_valid"}, {31'd0, rd_valid}, 32'd1);
    check(req, rd_data, exp);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic t_reset;
    check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R1 rd_data", rd_data, 32'd0);
  endtask

  task automatic t_first_write;
    cyc(1'b1, 1'b1, 6'd5, 32'h1111_2222);
    rd_chk("R7", 6'd5, 32'hA5A5_0001, 32'hA5A5_0001);
    cyc(1'b0, 1'b0, 6'd0, 32'hDEAD_BEEF);
    check("R9 idle rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R10 idle rd_data", rd_data, 32'hA5A5_0001);
    rd_chk("R5", 6'd5, 32'h0BAD_0BAD, 32'hA5A5_0001);
    rd_chk("R9", 6'd5, 32'h0, 32'hA5A5_0001);
  endtask

  task automatic t_commit;
    cyc(1'b1, 1'b1, 6'd9, 32'h5555_5555);
    cyc(1'b0, 1'b0, 6'd0, 32'h0000_0909);
    rd_chk("R4", 6'd5, 32'h0, 32'hA5A5_0001);
    rd_chk("R3", 6'd9, 32'h0, 32'h0000_0909);
  endtask

  task automatic t_back_to_back;
    cyc(1'b1, 1'b1, 6'd12, 32'h7777_7777);
    cyc(1'b1, 1'b1, 6'd13, 32'h0000_1212);
    cyc(1'b0, 1'b0, 6'd0, 32'h0000_1313);
    cyc(1'b1, 1'b1, 6'd20, 32'hFFFF_FFFF);
    cyc(1'b0, 1'b0, 6'd0, 32'h0000_2020);
    rd_chk("R8", 6'd12, 32'h0, 32'h0000_1212);
    rd_chk("R4 b2b", 6'd13, 32'h0, 32'h0000_1313);
    rd_chk("R5 b2b", 6'd20, 32'h0, 32'h0000_2020);
    rd_chk("R6", 6'd9, 32'h0, 32'h0000_0909);
  endtask

  task automatic t_rewrite;
    cyc(1'b1, 1'b1, 6'd12, 32'h0);
    cyc(1'b0, 1'b0, 6'd0, 32'hC0DE_0012);
    rd_chk("R11 held", 6'd12, 32'h0, 32'hC0DE_0012);
    cyc(1'b1, 1'b1, 6'd30, 32'h0);
    cyc(1'b0, 1'b0, 6'd0, 32'h0000_3030);
    rd_chk("R11 array", 6'd12, 32'h0, 32'hC0DE_0012);
    rd_chk("R6 after rewrite", 6'd20, 32'h0, 32'h0000_2020);
    rd_chk("R5 last", 6'd30, 32'h0, 32'h0000_3030);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_first_write();
    t_commit();
    t_back_to_back();
    t_rewrite();
    cyc(1'b0, 1'b0, 6'd0, 32'h0);
    summary();
  end
endmodule